// File: doc/BRIEF.md
# Pushbutton Reset Debounce Controller

This block sits on an active-low reset line that is shared with a pushbutton. It senses the line level through a synchronizer and can pull the same line low through an open-drain style enable. While the block is idle, a press pulls the line low. The block takes that falling level as the start of a press and holds the line low itself for a fixed debounce interval, so contact bounce cannot be seen.

When the interval ends, the block lets go of the line and waits for the synchronizer to settle before it reads the line again. A line that reads high means the press was already over, and a timed reset pulse follows at once. A line that still reads low means the block waits for the button to come up, and issues the pulse on release. The pulse is the line held low by the block for the same fixed interval.

After the pulse, the block does not re-arm until it has seen the line high, so a button that stays stuck down cannot retrigger. A status flag marks every phase from the start of debounce to the end of the pulse. The interval is a parameter counted in clock cycles, for example 250 ms times the clock frequency.

Top module: `pb_reset_ctrl`

## Requirements
- R1: While `por_n` is low, `drive_low` and `busy` are 0 without waiting for a clock edge, and the block is idle and unarmed.
- R2: In idle, once the block is armed, a line level that goes from high to low is detected through a two-flop synchronizer. `drive_low` is 1 after the third rising clock edge that samples the line low.
- R3: The debounce hold keeps `drive_low` at 1 for exactly `HOLD_CYCLES` clock cycles. Any line activity during the hold has no effect on its length.
- R4: After the hold, `drive_low` is 0 for exactly `SYNC_STAGES+1` cycles (3 by default) while the line settles. If the line then reads high, the reset pulse starts immediately.
- R5: If the line still reads low after settling, `drive_low` stays 0 until the line reads high. `drive_low` is 1 after the third rising edge that samples the line high.
- R6: The reset pulse keeps `drive_low` at 1 for exactly `HOLD_CYCLES` cycles.
- R7: `busy` is 1 from the first debounce cycle through the last pulse cycle, including settle and wait-for-release, and 0 in idle. `drive_low` is never 1 while `busy` is 0.
- R8: After a pulse, the block re-arms only once the synchronized line reads high. A line held low straight after a pulse never starts a new debounce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| line_in | input | 1 | Sensed level of the shared reset/button line |
| drive_low | output | 1 | When 1, the line is pulled low by the block |
| busy | output | 1 | High during debounce, settle, wait-for-release and reset pulse |

## Verification
The hardest situation to reach from the ports is a line that is still low at the moment the block lets go of it. This can be a button held through the whole debounce hold, or one held down straight after the pulse ends. The bench models the line as the wired AND of the button and the block's own pull-down. Random trials choose between a short press released inside the hold and a long press released a random number of cycles after settling. Each trial bounces the button during the hold. Directed trials press again the instant a pulse ends, to show that the block stays unarmed, and assert power-on reset in the middle of a debounce hold.

// File: rtl/pb_reset_ctrl.sv
module pb_reset_ctrl #(
  parameter int unsigned HOLD_CYCLES = 12_500_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic line_in,
  output logic drive_low,
  output logic busy
);

  localparam int unsigned SETTLE_CYCLES = SYNC_STAGES + 1;
  localparam int unsigned CNT_MAX = (HOLD_CYCLES > SETTLE_CYCLES) ? HOLD_CYCLES : SETTLE_CYCLES;
  localparam int unsigned CW = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_DEB, ST_SETTLE, ST_WAIT, ST_PULSE} state_t;

  state_t                 state;
  logic [CW-1:0]          cnt;
  logic                   armed;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_s;

  assign line_s    = sync_q[SYNC_STAGES-1];
  assign drive_low = (state == ST_DEB) || (state == ST_PULSE);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (!armed) begin
            armed <= line_s;
          end else if (!line_s) begin
            armed <= 1'b0;
            state <= ST_DEB;
          end
        end
        ST_DEB: begin
          if (cnt == HOLD_LAST) begin
            cnt   <= '0;
            state <= ST_SETTLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (cnt == SETTLE_LAST) begin
            cnt   <= '0;
            state <= line_s ? ST_PULSE : ST_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          cnt <= '0;
          if (line_s) state <= ST_PULSE;
        end
        ST_PULSE: begin
          if (cnt == HOLD_LAST) begin
            cnt   <= '0;
            armed <= 1'b0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          cnt   <= '0;
          state <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/pb_reset_ctrl_chk.sv
module pb_reset_ctrl_chk #(
  parameter int unsigned HOLD_CYCLES = 12_500_000
) (
  input logic clk,
  input logic por_n,
  input logic drive_low,
  input logic busy
);

  localparam int unsigned RW = $clog2(HOLD_CYCLES + 2);

  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         run <= '0;
    else if (drive_low) run <= run + 1'b1;
    else                run <= '0;
  end

  // R7
  drive_needs_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
    drive_low |-> busy);

  // R2
  busy_starts_driving_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(busy) |-> drive_low);

  // R7
  busy_ends_with_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(busy) |-> $past(drive_low));

  // R3
  hold_not_too_long_chk: assert property (@(posedge clk) disable iff (!por_n)
    drive_low |-> (run < RW'(HOLD_CYCLES)));

  // R6
  hold_not_too_short_chk: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(drive_low) && run != '0) |-> (run == RW'(HOLD_CYCLES)));

  // R4
  settle_gap_chk: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(drive_low) && busy) |=> !drive_low);

endmodule

bind pb_reset_ctrl pb_reset_ctrl_chk #(.HOLD_CYCLES(HOLD_CYCLES)) i_pb_reset_ctrl_chk (
  .clk(clk), .por_n(por_n), .drive_low(drive_low), .busy(busy)
);

// File: tb/test_pb_reset_ctrl.sv
module test_pb_reset_ctrl;
  localparam int unsigned HOLD = 20;
  localparam int unsigned SYNC = 2;

  logic clk = 1'b0;
  logic por_n;
  logic button = 1'b0;
  logic drive_low, busy;
  logic line_in;
  int n_chk = 0;
  int n_bad = 0;

  assign line_in = ~(drive_low | button);

  always #4 clk = ~clk;

  pb_reset_ctrl #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC)) i_pb_reset_ctrl (
    .clk(clk), .por_n(por_n), .line_in(line_in), .drive_low(drive_low), .busy(busy)
  );

  function automatic int exp_detect();     return SYNC + 1; endfunction
  function automatic int exp_settle_gap(); return SYNC + 1; endfunction
  function automatic int exp_release_gap(); return SYNC; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic trial(input bit long_press, input bit bounce, input int extra);
    int lat, deb, gap, pl;
    bit busy_ok;
    button = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!drive_low && lat < 50);
    chk(lat == exp_detect(), "R2 press latency", lat, exp_detect());
    deb = 1;
    busy_ok = 1'b1;
    while (1) begin
      if (deb >= HOLD - 2) button = long_press;
      else if (bounce) button = 1'($urandom_range(0, 1));
      @(negedge clk);
      if (!busy) busy_ok = 1'b0;
      if (!drive_low) break;
      deb++;
      if (deb > 4 * HOLD) break;
    end
    chk(deb == HOLD, "R3 debounce length", deb, HOLD);
    gap = 1;
    if (!long_press) begin
      while (!drive_low && gap < 50) begin
        @(negedge clk);
        if (!busy) busy_ok = 1'b0;
        if (!drive_low) gap++;
      end
      chk(gap == exp_settle_gap(), "R4 settle gap", gap, exp_settle_gap());
    end else begin
      for (int i = 0; i < extra; i++) begin
        @(negedge clk);
        if (!busy) busy_ok = 1'b0;
        if (drive_low) gap = -1000;
      end
      chk(gap == 1, "R5 no pulse while held", gap, 1);
      button = 1'b0;
      gap = 0;
      do begin @(negedge clk); if (!drive_low) gap++; end while (!drive_low && gap < 50);
      chk(gap == exp_release_gap(), "R5 release latency", gap, exp_release_gap());
    end
    pl = 1;
    while (1) begin
      @(negedge clk);
      if (!drive_low) break;
      if (!busy) busy_ok = 1'b0;
      pl++;
      if (pl > 4 * HOLD) break;
    end
    chk(pl == HOLD, "R6 pulse length", pl, HOLD);
    chk(busy_ok, "R7 busy through cycle", busy_ok, 1);
    chk(busy == 1'b0, "R7 busy low after pulse", busy, 0);
  endtask

  initial begin
    int ticks;
    ticks = 0;
    while (ticks < 200000) begin @(posedge clk); ticks++; end
    chk(1'b0, "watchdog", ticks, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int seen;
    void'($urandom(32'd2718));
    por_n = 1'b0;
    #1;
    chk(drive_low == 1'b0 && busy == 1'b0, "R1 reset outputs", {drive_low, busy}, 0);
    idle_wait(3);
    por_n = 1'b1;
    idle_wait(8);
    chk(busy == 1'b0, "R1 idle after reset", busy, 0);

    trial(1'b0, 1'b0, 0);
    idle_wait(6);
    trial(1'b1, 1'b0, 3);
    idle_wait(6);

    // R8: press again the moment the pulse ends
    trial(1'b0, 1'b1, 0);
    button = 1'b1;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (drive_low || busy) seen++;
    end
    chk(seen == 0, "R8 stuck line ignored", seen, 0);
    button = 1'b0;
    idle_wait(6);
    trial(1'b0, 1'b0, 0);
    idle_wait(6);

    for (int t = 0; t < 12; t++) begin
      trial(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), int'($urandom_range(3, 12)));
      idle_wait(int'($urandom_range(5, 15)));
    end

    // R1: asynchronous reset in the middle of a debounce hold
    button = 1'b1;
    idle_wait(8);
    #1;
    por_n = 1'b0;
    #1;
    chk(drive_low == 1'b0 && busy == 1'b0, "R1 async reset mid-hold", {drive_low, busy}, 0);
    button = 1'b0;
    idle_wait(2);
    por_n = 1'b1;
    idle_wait(6);
    trial(1'b1, 1'b1, 7);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule